// File: doc/BRIEF.md
# Supervisory Timer with Safe-Frequency Fallback

This block watches over a clock-generation subsystem. While it is enabled it counts down a programmable number of coarse time units, each built from a fixed number of millisecond ticks. By default a unit is 290 ticks, and the register reset value of 16 units gives a default window of 4.64 s. Software keeps the system alive by pulsing a service strobe before the window runs out. Each strobe restarts the whole interval.

When the window runs out, the block takes three actions on the same clock edge. It latches an alarm flag that software can read. It replaces the frequency-select code it drives onward with a fallback code. It starts an active-low system reset pulse, which lasts a fixed number of ticks. A select input chooses the fallback code. It is either a dedicated 5-bit safe-code field or the code that was latched from the power-on straps. The alarm and the fallback code stay in force until software clears the alarm or turns the timer off. The reset pulse ends on its own.

Top module: `wdt_safe_freq`

## Requirements
- R1: While the synchronous reset is high, `alarm_o` is 0, `sys_rst_n_o` is 1 and `freq_code_o` equals `strap_code_i`.
- R2: While `wd_en_i` is 0, no number of ticks raises `alarm_o` or pulls `sys_rst_n_o` low.
- R3: After the timer is enabled with `count_i` = N (N >= 1), `alarm_o` rises on the clock edge that samples the (N*UNIT_TICKS)-th tick, and not before.
- R4: A count of 0 expires at the first unit boundary, on the UNIT_TICKS-th tick.
- R5: On the edge where `alarm_o` rises, and for as long as it stays high, `freq_code_o` carries `safe_code_i` when `safe_from_reg_i` is 1 and `strap_code_i` when it is 0.
- R6: `sys_rst_n_o` goes low on the expiry edge. It stays low for exactly RST_TICKS tick samples (the expiry tick included) and then returns high, even though the alarm is still set.
- R7: Once set, `alarm_o` stays high until a cycle with `alarm_clr_i` = 1 or `wd_en_i` = 0 clears it. After the clear, `freq_code_o` returns to `req_code_i`.
- R8: A one-cycle `kick_i` restarts the full interval. After a kick, expiry comes N*UNIT_TICKS ticks later, and no expiry can happen on the kick cycle.
- R9: While `alarm_o` is 0, `freq_code_o` equals the `req_code_i` value of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle millisecond tick |
| wd_en_i | input | 1 | Timer enable (1 = running) |
| count_i | input | CNT_W | Timeout in units of UNIT_TICKS ticks |
| safe_code_i | input | CODE_W | Dedicated fallback select code |
| safe_from_reg_i | input | 1 | 1 = fallback from `safe_code_i`, 0 = from `strap_code_i` |
| strap_code_i | input | CODE_W | Select code latched from the power-on straps |
| req_code_i | input | CODE_W | Select code requested in normal operation |
| kick_i | input | 1 | Service strobe; restarts the interval |
| alarm_clr_i | input | 1 | Clears the alarm flag |
| freq_code_o | output | CODE_W | Active frequency-select code (registered) |
| alarm_o | output | 1 | Alarm status, 1 after expiry |
| sys_rst_n_o | output | 1 | Active-low system reset pulse |

## Verification
The checker assumes that `tick_i` and `kick_i` are single-cycle strobes. It also assumes that `alarm_clr_i` is a short pulse, and that the code and select inputs are quasi-static. Its code properties therefore compare the registered output with the inputs of the previous cycle only. The bench drives every input on the falling edge. It spaces ticks two clocks apart, so that no tick coincides with a kick, a clear or an enable change. It uses a small unit length (3 ticks) and a short reset pulse (2 ticks). With these values it sweeps count values 0 to 4 against both fallback sources, and it computes each expiry tick as max(N,1)*3.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic {
    PULSE_IDLE = 1'b0,
    PULSE_LOW  = 1'b1
  } pulse_state_e;

  // width of a counter that must hold 0 .. n-1
  function automatic int cnt_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/wdt_unit_prescaler.sv
module wdt_unit_prescaler #(
  parameter int UNIT_TICKS = 290
) (
  input  logic clk,
  input  logic rst,
  input  logic restart_i,
  input  logic tick_i,
  output logic unit_o
);
  localparam int PW = wdt_pkg::cnt_bits(UNIT_TICKS);
  localparam logic [PW-1:0] LAST = PW'(UNIT_TICKS - 1);
  localparam logic [PW-1:0] ONE  = PW'(1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      pre_q <= '0;
    end else if (tick_i) begin
      pre_q <= (pre_q == LAST) ? '0 : pre_q + ONE;
    end
  end

  assign unit_o = tick_i & ~restart_i & (pre_q == LAST);

endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             unit_i,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst || load_i) begin
      remain_q <= load_val_i;
    end else if (unit_i && (remain_q > ONE)) begin
      remain_q <= remain_q - ONE;
    end
  end

  // a remaining count of 1 or 0 ends at this unit boundary
  assign expire_o = unit_i & ~load_i & (remain_q <= ONE);

endmodule

// File: rtl/wdt_rst_stretch.sv
module wdt_rst_stretch #(
  parameter int RST_TICKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic fire_i,
  input  logic tick_i,
  output logic rst_n_o
);
  import wdt_pkg::*;

  localparam int RW = cnt_bits(RST_TICKS);
  localparam logic [RW-1:0] LAST = RW'(RST_TICKS - 1);
  localparam logic [RW-1:0] ONE  = RW'(1);

  pulse_state_e  state_q;
  logic [RW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PULSE_IDLE;
      cnt_q   <= '0;
    end else if (fire_i) begin
      state_q <= PULSE_LOW;
      cnt_q   <= '0;
    end else if ((state_q == PULSE_LOW) && tick_i) begin
      if (cnt_q == LAST) begin
        state_q <= PULSE_IDLE;
      end else begin
        cnt_q <= cnt_q + ONE;
      end
    end
  end

  assign rst_n_o = (state_q == PULSE_IDLE);

endmodule

// File: rtl/wdt_safe_freq.sv
module wdt_safe_freq #(
  parameter int CNT_W      = 8,
  parameter int CODE_W     = 5,
  parameter int UNIT_TICKS = 290,
  parameter int RST_TICKS  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              wd_en_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [CODE_W-1:0] safe_code_i,
  input  logic              safe_from_reg_i,
  input  logic [CODE_W-1:0] strap_code_i,
  input  logic [CODE_W-1:0] req_code_i,
  input  logic              kick_i,
  input  logic              alarm_clr_i,
  output logic [CODE_W-1:0] freq_code_o,
  output logic              alarm_o,
  output logic              sys_rst_n_o
);
  logic              alarm_q;
  logic              alarm_d;
  logic              restart;
  logic              unit;
  logic              expire;
  logic [CODE_W-1:0] fallback;
  logic [CODE_W-1:0] code_q;

  // interval restarts when off, when serviced, or while the alarm holds
  assign restart = ~wd_en_i | kick_i | alarm_q;

  wdt_unit_prescaler #(.UNIT_TICKS(UNIT_TICKS)) u_pre (
    .clk       (clk),
    .rst       (rst),
    .restart_i (restart),
    .tick_i    (tick_i),
    .unit_o    (unit)
  );

  wdt_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .load_i     (restart),
    .load_val_i (count_i),
    .unit_i     (unit),
    .expire_o   (expire)
  );

  wdt_rst_stretch #(.RST_TICKS(RST_TICKS)) u_rst (
    .clk     (clk),
    .rst     (rst),
    .fire_i  (expire),
    .tick_i  (tick_i),
    .rst_n_o (sys_rst_n_o)
  );

  assign fallback = safe_from_reg_i ? safe_code_i : strap_code_i;
  assign alarm_d  = wd_en_i & (expire | (alarm_q & ~alarm_clr_i));

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_q <= 1'b0;
      code_q  <= strap_code_i;
    end else begin
      alarm_q <= alarm_d;
      code_q  <= alarm_d ? fallback : req_code_i;
    end
  end

  assign alarm_o     = alarm_q;
  assign freq_code_o = code_q;

endmodule

// File: rtl/wdt_safe_freq_chk.sv
module wdt_safe_freq_chk #(
  parameter int CODE_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              wd_en_i,
  input logic [CODE_W-1:0] safe_code_i,
  input logic              safe_from_reg_i,
  input logic [CODE_W-1:0] strap_code_i,
  input logic [CODE_W-1:0] req_code_i,
  input logic              kick_i,
  input logic              alarm_clr_i,
  input logic [CODE_W-1:0] freq_code_o,
  input logic              alarm_o,
  input logic              sys_rst_n_o
);
  logic past_valid = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) past_valid <= 1'b0;
    else     past_valid <= 1'b1;
  end

  AST_NO_EXPIRY_DISABLED: assert property (@(posedge clk) disable iff (rst)
    past_valid && $rose(alarm_o) |-> $past(wd_en_i)); // R2

  AST_SAFE_CODE: assert property (@(posedge clk) disable iff (rst)
    past_valid && alarm_o |->
      freq_code_o == $past(safe_from_reg_i ? safe_code_i : strap_code_i)); // R5

  AST_RST_ON_EXPIRY: assert property (@(posedge clk) disable iff (rst)
    past_valid && $fell(sys_rst_n_o) |-> $rose(alarm_o)); // R6

  AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (rst)
    alarm_o && wd_en_i && !alarm_clr_i |=> alarm_o); // R7

  AST_DIS_CLEARS_ALARM: assert property (@(posedge clk) disable iff (rst)
    !wd_en_i |=> !alarm_o); // R7

  AST_KICK_NO_EXPIRY: assert property (@(posedge clk) disable iff (rst)
    kick_i && !alarm_o |=> !alarm_o); // R8

  AST_NORMAL_CODE: assert property (@(posedge clk) disable iff (rst)
    past_valid && !alarm_o |-> freq_code_o == $past(req_code_i)); // R9

endmodule

bind wdt_safe_freq wdt_safe_freq_chk #(.CODE_W(CODE_W)) u_wdt_chk (
  .clk             (clk),
  .rst             (rst),
  .wd_en_i         (wd_en_i),
  .safe_code_i     (safe_code_i),
  .safe_from_reg_i (safe_from_reg_i),
  .strap_code_i    (strap_code_i),
  .req_code_i      (req_code_i),
  .kick_i          (kick_i),
  .alarm_clr_i     (alarm_clr_i),
  .freq_code_o     (freq_code_o),
  .alarm_o         (alarm_o),
  .sys_rst_n_o     (sys_rst_n_o)
);

// File: tb/test_wdt_safe_freq.sv
module test_wdt_safe_freq;
  localparam int CW = 8;
  localparam int KW = 5;
  localparam int U  = 3;
  localparam int RT = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick_i = 1'b0;
  logic          wd_en_i = 1'b0;
  logic [CW-1:0] count_i = '0;
  logic [KW-1:0] safe_code_i = '0;
  logic          safe_from_reg_i = 1'b0;
  logic [KW-1:0] strap_code_i = '0;
  logic [KW-1:0] req_code_i = '0;
  logic          kick_i = 1'b0;
  logic          alarm_clr_i = 1'b0;
  logic [KW-1:0] freq_code_o;
  logic          alarm_o;
  logic          sys_rst_n_o;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  wdt_safe_freq #(.CNT_W(CW), .CODE_W(KW), .UNIT_TICKS(U), .RST_TICKS(RT)) i_wdt_safe_freq (
    .clk (clk), .rst (rst), .tick_i (tick_i), .wd_en_i (wd_en_i),
    .count_i (count_i), .safe_code_i (safe_code_i), .safe_from_reg_i (safe_from_reg_i),
    .strap_code_i (strap_code_i), .req_code_i (req_code_i), .kick_i (kick_i),
    .alarm_clr_i (alarm_clr_i), .freq_code_o (freq_code_o), .alarm_o (alarm_o),
    .sys_rst_n_o (sys_rst_n_o)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick1();
    @(negedge clk) tick_i = 1'b1;
    @(negedge clk) tick_i = 1'b0;
  endtask

  task automatic strobe_kick();
    @(negedge clk) kick_i = 1'b1;
    @(negedge clk) kick_i = 1'b0;
  endtask

  task automatic strobe_clr();
    @(negedge clk) alarm_clr_i = 1'b1;
    @(negedge clk) alarm_clr_i = 1'b0;
  endtask

  task automatic set_en(input logic v);
    @(negedge clk) wd_en_i = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int first;
    int low;
    int exp_t;
    int exp_code;
    strap_code_i = 5'h1C;
    req_code_i   = 5'h03;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 alarm", alarm_o, 0);
    check("R1 rst_n", sys_rst_n_o, 1);
    check("R1 code", freq_code_o, 5'h1C);
    rst = 1'b0;
    @(negedge clk);

    // R2 and R9: disabled timer never fires, code follows request
    count_i = 1;
    for (int t = 0; t < 12; t++) tick1();
    check("R2 alarm while off", alarm_o, 0);
    check("R2 rst_n while off", sys_rst_n_o, 1);
    check("R9 code follows request", freq_code_o, 5'h03);
    req_code_i = 5'h11;
    @(negedge clk);
    check("R9 code follows new request", freq_code_o, 5'h11);

    // R3 R4 R5 R6 R7: sweep counts against both fallback sources
    for (int n = 0; n < 5; n++) begin
      for (int src = 0; src < 2; src++) begin
        count_i         = CW'(n);
        safe_from_reg_i = src[0];
        safe_code_i     = KW'(5'h15 ^ n);
        strap_code_i    = KW'(5'h0A + n);
        exp_code        = src ? (5'h15 ^ n) : (5'h0A + n);
        exp_t           = ((n == 0) ? 1 : n) * U;
        set_en(1'b1);
        first = -1;
        low   = 0;
        for (int t = 1; t <= exp_t + RT + 2; t++) begin
          tick1();
          if (alarm_o && first < 0) begin
            first = t;
            check("R5 fallback code on expiry edge", freq_code_o, exp_code);
          end
          if (!sys_rst_n_o) low++;
        end
        if (n == 0) check("R4 zero count expiry tick", first, exp_t);
        else        check("R3 expiry tick", first, exp_t);
        check("R6 reset pulse ticks", low, RT);
        check("R6 reset released", sys_rst_n_o, 1);
        check("R7 alarm held", alarm_o, 1);
        check("R5 fallback code held", freq_code_o, exp_code);
        strobe_clr();
        check("R7 alarm cleared", alarm_o, 0);
        check("R7 code restored", freq_code_o, 5'h11);
        set_en(1'b0);
      end
    end

    // R8: kick restarts the full interval
    count_i = 2;
    set_en(1'b1);
    for (int t = 0; t < 5; t++) tick1();
    check("R8 no alarm before kick", alarm_o, 0);
    strobe_kick();
    for (int t = 0; t < 5; t++) tick1();
    check("R8 no alarm 5 ticks after kick", alarm_o, 0);
    tick1();
    check("R8 alarm 6 ticks after kick", alarm_o, 1);

    // R7: disabling also clears the alarm
    set_en(1'b0);
    check("R7 disable clears alarm", alarm_o, 0);
    check("R7 code after disable", freq_code_o, 5'h11);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule